// File: doc/BRIEF.md
# 64-to-66-bit Width Gearbox

The block converts a stream of 64-bit words into a stream of 66-bit words carrying the same bits in the same order. Everything runs on one clock. An input word is taken on any edge where its valid strobe is high. An output word is produced on every edge where the block already holds at least 66 unused bits. Bits are packed least-significant first. Bit 0 of the first input word after reset is therefore bit 0 of the first output word, and the concatenated output bit stream equals the concatenated input bit stream.

Under continuous input, 33 input words carry exactly as many bits as 32 output words. The output therefore idles for one edge in every 33. A phase counter that runs modulo 33 over accepted words gives the bit offset at which each new word is written into a 192-bit accumulation register. A separate fill counter decides when an output word can be released. Before the first output appears, two input words must be held. The one-slot gap that absorbs the 33:32 rate difference comes from the same rule.

Top module: `gear64to66`

## Requirements
- R1: Output bits follow input bits in order, least-significant bit first. Bit 0 of the first word accepted after reset is bit 0 of the first output word. The first output word equals {second word[1:0], first word[63:0]}.
- R2: On every clock edge where the held bit count is at least 66, outVld is high in the following cycle and 66 bits leave. On edges where fewer than 66 bits are held, outVld is low in the following cycle. Each accepted word adds 64 to the held count and each output word removes 66.
- R3: Words are accepted on every edge starting right after reset. Then the output idles on edges 1, 2, 35, 68, … (edge n idles when n mod 33 = 2), and every other edge produces a word. That gives 32 output words per 33 input words. The held bit count always equals (64 × accepted words mod 33) mod 66, plus 0 or 66.
- R4: No output word is valid until two input words have been accepted. With back-to-back input from reset, the first output is valid in the cycle after the third clock edge.
- R5: A synchronous reset empties the block and discards any partial data, whatever the input strobe does. After reset, outVld and outData are zero and the next accepted word starts a new stream at output bit 0.
- R6: When inVld is low, inData has no effect on any output word.
- R7: outData keeps its last value while outVld is low.
- R8: With any pattern of gaps in the input, the held bit count never exceeds 128 and no bit is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| inVld | input | 1 | Input word valid |
| inData | input | 64 | Input word, bit 0 earliest |
| outVld | output | 1 | Output word valid |
| outData | output | 66 | Output word, bit 0 earliest |

## Verification
Both output signals are registered. The output decision taken at an edge is based on the bit count held before that edge, so its result is visible right after that same edge. The bench keeps its own count of held bits and predicts outVld for each edge from the count before the edge. It samples the ports one nanosecond after the edge, compares outVld, and pops 66 bits from a reference bit queue to compare with outData. Explicit checks pin the first output word to edge 3 after reset and the idle edges of continuous input to 35 and 68. A reset applied mid-stream is followed by the same edge-3 rule.

// File: rtl/gear_pkg.sv
package gear_pkg;

  // Stream widths and accumulation depth
  localparam int IN_W    = 64;
  localparam int OUT_W   = 66;
  localparam int ACC_W   = 192;
  // Input words per repeating phase cycle (lcm(IN_W,OUT_W)/IN_W)
  localparam int PHASE_N = 33;

  localparam int FILL_W  = $clog2(ACC_W + 1);
  localparam int PH_W    = $clog2(PHASE_N);

  // Strobes from control to datapath
  typedef struct packed {
    logic              shift;   // release OUT_W low bits this edge
    logic              load;    // write the input word this edge
    logic [FILL_W-1:0] insOff;  // bit offset of the written word
  } gear_ctl_t;

endpackage

// File: rtl/gear_ctrl.sv
module gear_ctrl
  import gear_pkg::*;
#(
  parameter int InW    = IN_W,
  parameter int OutW   = OUT_W,
  parameter int PhaseN = PHASE_N
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inVld,
  output gear_ctl_t         ctl,
  output logic [FILL_W-1:0] fillLvl,
  output logic [PH_W-1:0]   phase
);

  localparam logic [FILL_W-1:0] OutWF  = FILL_W'(OutW);
  localparam logic [FILL_W-1:0] InWF   = FILL_W'(InW);
  localparam logic [PH_W-1:0]   PhLast = PH_W'(PhaseN - 1);

  logic              shiftNow;
  logic [FILL_W-1:0] remain;
  logic [FILL_W-1:0] base;
  logic [FILL_W-1:0] fillNext;
  logic [PH_W-1:0]   phaseNext;

  // Offset of the word that arrives in a given phase: residue of its first bit
  function automatic logic [FILL_W-1:0] phaseBase(input logic [PH_W-1:0] p);
    return FILL_W'((InW * int'(p)) % OutW);
  endfunction

  always_comb begin
    shiftNow  = (fillLvl >= OutWF);
    remain    = shiftNow ? (fillLvl - OutWF) : fillLvl;
    base      = phaseBase(phase);
    fillNext  = remain + (inVld ? InWF : '0);
    phaseNext = phase;
    if (inVld) begin
      phaseNext = (phase == PhLast) ? '0 : phase + 1'b1;
    end
  end

  always_comb begin
    ctl.shift  = shiftNow;
    ctl.load   = inVld;
    ctl.insOff = base;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fillLvl <= '0;
      phase   <= '0;
    end else begin
      fillLvl <= fillNext;
      phase   <= phaseNext;
    end
  end

endmodule

// File: rtl/gear_dpath.sv
module gear_dpath
  import gear_pkg::*;
#(
  parameter int InW  = IN_W,
  parameter int OutW = OUT_W,
  parameter int AccW = ACC_W
) (
  input  logic            clk,
  input  logic            rst,
  input  gear_ctl_t       ctl,
  input  logic [InW-1:0]  inData,
  output logic            outVld,
  output logic [OutW-1:0] outData
);

  localparam int PadW = AccW - InW;

  logic [AccW-1:0] acc;
  logic [AccW-1:0] kept;
  logic [AccW-1:0] ins;

  // Bits above the held count are always zero, so insertion is a plain OR
  always_comb begin
    kept = ctl.shift ? (acc >> OutW) : acc;
    ins  = ctl.load ? ({{PadW{1'b0}}, inData} << ctl.insOff) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc     <= '0;
      outVld  <= 1'b0;
      outData <= '0;
    end else begin
      acc    <= kept | ins;
      outVld <= ctl.shift;
      if (ctl.shift) begin
        outData <= acc[OutW-1:0];
      end
    end
  end

endmodule

// File: rtl/gear64to66.sv
module gear64to66
  import gear_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inVld,
  input  logic [IN_W-1:0]   inData,
  output logic              outVld,
  output logic [OUT_W-1:0]  outData
);

  gear_ctl_t         ctl;
  logic [FILL_W-1:0] fillLvl;
  logic [PH_W-1:0]   phase;

  gear_ctrl #(
    .InW    (IN_W),
    .OutW   (OUT_W),
    .PhaseN (PHASE_N)
  ) i_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inVld   (inVld),
    .ctl     (ctl),
    .fillLvl (fillLvl),
    .phase   (phase)
  );

  gear_dpath #(
    .InW  (IN_W),
    .OutW (OUT_W),
    .AccW (ACC_W)
  ) i_dpath (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .inData  (inData),
    .outVld  (outVld),
    .outData (outData)
  );

endmodule

// File: rtl/gear64to66_chk.sv
module gear64to66_chk
  import gear_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              inVld,
  input logic [IN_W-1:0]   inData,
  input logic              outVld,
  input logic [OUT_W-1:0]  outData,
  input logic [FILL_W-1:0] fillLvl,
  input logic [PH_W-1:0]   phase
);

  localparam int MaxFill = ACC_W - IN_W;

  AST_VLD_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (int'(fillLvl) >= OUT_W) |=> outVld); // R2

  AST_NO_VLD_WHEN_SHORT: assert property (@(posedge clk) disable iff (rst)
    (int'(fillLvl) < OUT_W) |=> !outVld); // R2

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> int'(fillLvl) == int'($past(fillLvl)) + ($past(inVld) ? IN_W : 0)
                                     - (outVld ? OUT_W : 0)); // R8

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    (int'(fillLvl) <= MaxFill) && (int'(fillLvl) <= 2 * OUT_W - 2)); // R8

  AST_PHASE_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (int'(phase) < PHASE_N) &&
    ((int'(fillLvl) % OUT_W) == ((IN_W * int'(phase)) % OUT_W))); // R3

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (fillLvl == '0) && (phase == '0) && !outVld && (outData == '0)); // R5

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !outVld) |-> $stable(outData)); // R7

endmodule

bind gear64to66 gear64to66_chk i_chk (.*);

// File: tb/test_gear64to66.sv
module test_gear64to66;

  logic        clk;
  logic        rst;
  logic        inVld;
  logic [63:0] inData;
  logic        outVld;
  logic [65:0] outData;

  int testCnt = 0;
  int failCnt = 0;
  int mFill   = 0;
  bit stream[$];
  logic [31:0] seed = 32'h1234_5678;
  logic [65:0] lastOut = '0;

  gear64to66 i_gear64to66 (
    .clk     (clk),
    .rst     (rst),
    .inVld   (inVld),
    .inData  (inData),
    .outVld  (outVld),
    .outData (outData)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] rnd64();
    logic [31:0] hi;
    seed = seed * 32'd1664525 + 32'd1013904223;
    hi   = seed;
    seed = seed * 32'd1664525 + 32'd1013904223;
    return {hi, seed};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [65:0] act, input logic [65:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One clock edge: drive, wait past the edge, compare with the model
  task automatic step(input logic v, input logic [63:0] d, input string req);
    logic        expV;
    logic [65:0] expD;
    inVld  = v;
    inData = d;
    @(posedge clk);
    #1;
    expV = (mFill >= 66);
    chk(outVld === expV, "R2", "outVld", {65'b0, outVld}, {65'b0, expV});
    if (expV) begin
      for (int b = 0; b < 66; b++) expD[b] = stream.pop_front();
      chk(outData === expD, req, "outData", outData, expD);
      lastOut = outData;
      mFill -= 66;
    end
    if (v) begin
      for (int b = 0; b < 64; b++) stream.push_back(d[b]);
      mFill += 64;
    end
    inVld = 1'b0;
  endtask

  task automatic doReset();
    rst    = 1'b1;
    inVld  = 1'b1;
    inData = rnd64();
    repeat (2) @(posedge clk);
    #1;
    rst   = 1'b0;
    inVld = 1'b0;
    stream.delete();
    mFill   = 0;
    lastOut = '0;
    chk(outVld === 1'b0, "R5", "outVld after reset", {65'b0, outVld}, 66'd0);
    chk(outData === 66'd0, "R5", "outData after reset", outData, 66'd0);
  endtask

  task automatic drain(input string req);
    while (mFill >= 66) step(1'b0, rnd64(), req);
  endtask

  task automatic t_prefill();
    logic [63:0] a, b;
    doReset();
    a = rnd64();
    b = rnd64();
    step(1'b1, a, "R1");
    chk(outVld === 1'b0, "R4", "outVld after word 1", {65'b0, outVld}, 66'd0);
    step(1'b1, b, "R1");
    chk(outVld === 1'b0, "R4", "outVld after word 2", {65'b0, outVld}, 66'd0);
    step(1'b0, rnd64(), "R1");
    chk(outVld === 1'b1, "R4", "outVld at edge 3", {65'b0, outVld}, 66'd1);
    chk(outData === {b[1:0], a}, "R1", "first word order", outData, {b[1:0], a});
    drain("R1");
  endtask

  task automatic t_continuous();
    int outs  = 0;
    int idleA = 0;
    int idleB = 0;
    doReset();
    for (int i = 1; i <= 99; i++) begin
      step(1'b1, rnd64(), "R1");
      if (outVld) outs++;
      else if (i > 2) begin
        if (idleA == 0) idleA = i;
        else if (idleB == 0) idleB = i;
      end
    end
    chk(outs == 95, "R3", "outputs in 99 edges", 66'(outs), 66'd95);
    chk(idleA == 35, "R3", "first idle edge", 66'(idleA), 66'd35);
    chk(idleB == 68, "R3", "second idle edge", 66'(idleB), 66'd68);
    drain("R3");
  endtask

  task automatic t_ignore();
    doReset();
    step(1'b1, rnd64(), "R6");
    for (int i = 0; i < 5; i++) step(1'b0, rnd64(), "R6");
    step(1'b1, rnd64(), "R6");
    for (int i = 0; i < 3; i++) step(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
    step(1'b1, rnd64(), "R6");
    step(1'b1, 64'h0, "R6");
    drain("R6");
    chk(mFill < 66, "R6", "model drained", 66'(mFill), 66'd0);
  endtask

  task automatic t_gaps();
    doReset();
    for (int i = 0; i < 400; i++) begin
      logic [63:0] r;
      r = rnd64();
      step(r[5:3] != 3'd0 && r[9:7] != 3'd1, rnd64(), "R8");
    end
    drain("R8");
  endtask

  task automatic t_hold();
    for (int i = 0; i < 4; i++) begin
      step(1'b0, rnd64(), "R7");
      chk(outData === lastOut, "R7", "outData held", outData, lastOut);
    end
  endtask

  task automatic t_midreset();
    logic [63:0] a, b;
    doReset();
    for (int i = 0; i < 3; i++) step(1'b1, rnd64(), "R5");
    doReset();
    a = rnd64();
    b = rnd64();
    step(1'b1, a, "R5");
    step(1'b1, b, "R5");
    step(1'b0, rnd64(), "R5");
    chk(outVld === 1'b1, "R5", "restart outVld", {65'b0, outVld}, 66'd1);
    chk(outData === {b[1:0], a}, "R5", "restart at bit 0", outData, {b[1:0], a});
    drain("R5");
  endtask

  initial begin
    #(20 * 200000);
    testCnt++;
    failCnt++;
    $display("FAIL watchdog all-requirements actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    rst    = 1'b1;
    inVld  = 1'b0;
    inData = '0;
    t_prefill();
    t_continuous();
    t_ignore();
    t_gaps();
    t_hold();
    t_midreset();
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule